// File: doc/BRIEF.md
# Receiver Front-End Control and Status Registers

This block is a small byte-wide register bank that sits between a host bus and the analog receiver front end. It holds three locations. A configuration word carries the static settings: gain select, calibration accuracy, data-pin output enables, off-timer prescale and discontinuous-mode select. A control word carries the gain lock, the two peak-detector tracking enables and two calibration-start bits. A read-only status word reports PLL lock, clock presence, the gain state actually applied and the two calibration completion flags.

Writing 1 to a calibration-start bit does three things: it sets the bit, it clears the matching done flag, and it sends a one-cycle start pulse to the external calibration engine. The bit stays set until the engine reports completion. At that point the bit clears itself and the done flag rises. The gain bit in the configuration word can be written at any time. It only reaches the amplifier while automatic gain control is enabled and the gain lock is off. Software sets gain manually by enabling AGC, writing the bit, and then disabling AGC.

Top module: `rxfe_csr`

## Requirements
- R1: After reset the configuration word reads 0x40, the control word reads 0x00, both done flags read 0, the applied gain state is high (1), and neither start output is asserted.
- R2: Configuration bits 6..0 (bit 6 gain, bit 5 accurate calibration, bits 4 and 3 data-pin output enables, bits 2..1 off-timer prescale, bit 0 discontinuous mode) are written and read back as given; bit 7 always reads 0.
- R3: In the control word only bit 6 (gain lock), bit 3 (FSK tracking), bit 2 (ASK tracking), bit 1 (polling-timer calibration start) and bit 0 (FSK calibration start) are stored; the other bits read 0. Writing 0 to a calibration-start bit leaves it unchanged.
- R4: Writing 1 to control bit 0 (or bit 1) sets that bit and clears its done flag. The matching start output (FSK or polling) is high for exactly the one cycle after the write edge.
- R5: A completion pulse on a calibration's done input while its start bit is set clears the start bit and sets its done flag at the same edge. A completion pulse while the start bit is clear changes nothing.
- R6: Status reads as bit 7 PLL lock, bit 6 applied gain, bit 5 clock alive, bits 4..2 zero, bit 1 polling-calibration done, bit 0 FSK-calibration done. Writes to the status address change no register.
- R7: The applied gain state takes configuration bit 6 at each edge where AGC enable is 1 and the gain lock is 0. Otherwise it holds its value.
- R8: Read data is 0 when read enable is low, and also for any address other than the configuration (1), control (2) and status (9) addresses.
- R9: When a write of 1 to a start bit and that calibration's completion pulse arrive in the same cycle, the write wins: the bit stays set, the done flag stays 0 and a new start pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable |
| busRdata | output | 8 | Read data, combinational |
| agcEn | input | 1 | Automatic gain control enable |
| pllLocked | input | 1 | PLL lock indication |
| clkAlive | input | 1 | Crystal clock present |
| fskCalDone | input | 1 | FSK calibration completion pulse |
| polCalDone | input | 1 | Polling-timer calibration completion pulse |
| fskCalStart | output | 1 | FSK calibration start pulse |
| polCalStart | output | 1 | Polling-timer calibration start pulse |
| gainHigh | output | 1 | Applied amplifier gain state |
| cfgWord | output | 8 | Configuration word to the front end |
| ctlWord | output | 8 | Control word to the front end |

## Verification
A stuck or lost calibration-start bit shows up in two places: on the control word at the next read, and as a missing or doubled start pulse one cycle after the write edge. A done flag that is not cleared or not set shows in the low status bits at the first read after the start or completion edge. A gain state that loads when it should not shows on gainHigh and status bit 6 one edge after the offending cycle. The bench therefore probes each of these points right after the edge that should have changed them, or left them unchanged.

// File: rtl/rxfe_csr_pkg.sv
package rxfe_csr_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_CFG, SEL_CTL, SEL_STS} rdSel_e;

  typedef struct packed {
    logic   cfgWr;
    logic   ctlWr;
    rdSel_e rdSel;
  } csrStrobes_t;

  localparam int CFG_GAIN_BIT = 6;
  localparam int CTL_LOCK_BIT = 6;
  localparam int CTL_TRKF_BIT = 3;
  localparam int CTL_TRKA_BIT = 2;
  localparam int NUM_CAL      = 2;
endpackage

// File: rtl/rxfe_csr_ctrl.sv
module rxfe_csr_ctrl
  import rxfe_csr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1,
  parameter int CTL_ADDR = 2,
  parameter int STS_ADDR = 9
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output csrStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] CfgA = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] CtlA = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] StsA = ADDR_W'(STS_ADDR);

  always_comb begin
    strb.cfgWr = busWe && (busAddr == CfgA);
    strb.ctlWr = busWe && (busAddr == CtlA);
    strb.rdSel = SEL_NONE;
    if (busRe) begin
      if (busAddr == CfgA)      strb.rdSel = SEL_CFG;
      else if (busAddr == CtlA) strb.rdSel = SEL_CTL;
      else if (busAddr == StsA) strb.rdSel = SEL_STS;
    end
  end
endmodule

// File: rtl/rxfe_csr_data.sv
module rxfe_csr_data
  import rxfe_csr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  csrStrobes_t strb,
  input  logic [7:0]  busWdata,
  input  logic        agcEn,
  input  logic        pllLocked,
  input  logic        clkAlive,
  input  logic [NUM_CAL-1:0] calDoneIn,
  output logic [NUM_CAL-1:0] calStartOut,
  output logic        gainHigh,
  output logic [7:0]  cfgWord,
  output logic [7:0]  ctlWord,
  output logic [7:0]  rdData
);
  localparam logic [7:0] CfgReset = 8'h40;
  localparam logic [7:0] CfgMask  = 8'h7F;

  logic [7:0]         cfgReg;
  logic               lockBit, trkFsk, trkAsk;
  logic               gainState;
  logic [NUM_CAL-1:0] calBusy, calFlag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg <= CfgReset;
    end else if (strb.cfgWr) begin
      cfgReg <= busWdata & CfgMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lockBit <= 1'b0;
      trkFsk  <= 1'b0;
      trkAsk  <= 1'b0;
    end else if (strb.ctlWr) begin
      lockBit <= busWdata[CTL_LOCK_BIT];
      trkFsk  <= busWdata[CTL_TRKF_BIT];
      trkAsk  <= busWdata[CTL_TRKA_BIT];
    end
  end

  // gain only follows the config bit while AGC runs unlocked
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gainState <= CfgReset[CFG_GAIN_BIT];
    end else if (agcEn && !lockBit) begin
      gainState <= cfgReg[CFG_GAIN_BIT];
    end
  end

  for (genvar i = 0; i < NUM_CAL; i++) begin : g_cal
    logic busy, flag, pulse;
    logic startReq;
    assign startReq = strb.ctlWr && busWdata[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy  <= 1'b0;
        flag  <= 1'b0;
        pulse <= 1'b0;
      end else begin
        pulse <= startReq;
        if (startReq) begin
          busy <= 1'b1;
          flag <= 1'b0;
        end else if (busy && calDoneIn[i]) begin
          busy <= 1'b0;
          flag <= 1'b1;
        end
      end
    end

    assign calBusy[i]     = busy;
    assign calFlag[i]     = flag;
    assign calStartOut[i] = pulse;
  end

  assign gainHigh = gainState;
  assign cfgWord  = cfgReg;
  assign ctlWord  = {1'b0, lockBit, 2'b00, trkFsk, trkAsk, calBusy};

  always_comb begin
    unique case (strb.rdSel)
      SEL_CFG: rdData = cfgReg;
      SEL_CTL: rdData = ctlWord;
      SEL_STS: rdData = {pllLocked, gainState, clkAlive, 3'b000, calFlag};
      default: rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/rxfe_csr.sv
module rxfe_csr
  import rxfe_csr_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CFG_ADDR = 1,
  parameter int CTL_ADDR = 2,
  parameter int STS_ADDR = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [7:0]        busRdata,
  input  logic              agcEn,
  input  logic              pllLocked,
  input  logic              clkAlive,
  input  logic              fskCalDone,
  input  logic              polCalDone,
  output logic              fskCalStart,
  output logic              polCalStart,
  output logic              gainHigh,
  output logic [7:0]        cfgWord,
  output logic [7:0]        ctlWord
);
  csrStrobes_t        strb;
  logic [NUM_CAL-1:0] calStart;

  rxfe_csr_ctrl #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .CTL_ADDR(CTL_ADDR), .STS_ADDR(STS_ADDR)
  ) u_ctrl (
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .strb(strb)
  );

  rxfe_csr_data u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busWdata(busWdata),
    .agcEn(agcEn), .pllLocked(pllLocked), .clkAlive(clkAlive),
    .calDoneIn({polCalDone, fskCalDone}), .calStartOut(calStart),
    .gainHigh(gainHigh), .cfgWord(cfgWord), .ctlWord(ctlWord),
    .rdData(busRdata)
  );

  assign fskCalStart = calStart[0];
  assign polCalStart = calStart[1];
endmodule

// File: rtl/rxfe_csr_chk.sv
module rxfe_csr_chk #(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 2,
  parameter int STS_ADDR = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic [7:0]        busRdata,
  input logic              agcEn,
  input logic              pllLocked,
  input logic              clkAlive,
  input logic              fskCalDone,
  input logic              polCalDone,
  input logic              fskCalStart,
  input logic              polCalStart,
  input logic              gainHigh,
  input logic [7:0]        cfgWord,
  input logic [7:0]        ctlWord
);
  logic ctlHit;
  assign ctlHit = busWe && (busAddr == ADDR_W'(CTL_ADDR));

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctlHit && busWdata[0] |=> fskCalStart && ctlWord[0]);

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWord[0] && fskCalDone && !(ctlHit && busWdata[0]) |=> !ctlWord[0]);

  a_r3_cal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ctlWord[1] && !polCalDone |=> ctlWord[1]);

  a_r7_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !agcEn || ctlWord[6] |=> $stable(gainHigh));

  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !busRe |-> busRdata == 8'h00);

  a_r6_status_live: assert property (@(posedge clk) disable iff (!rst_n)
    busRe && busAddr == ADDR_W'(STS_ADDR) |-> busRdata[7] == pllLocked && busRdata[5] == clkAlive);
endmodule

bind rxfe_csr rxfe_csr_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .STS_ADDR(STS_ADDR)) u_chk (.*);

// File: tb/rxfe_csr_bench.sv
module rxfe_csr_bench;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_CFG = 4'd1, A_CTL = 4'd2, A_STS = 4'd9;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic busWe = 0, busRe = 0, agcEn = 0, pllLocked = 0, clkAlive = 0;
  logic fskCalDone = 0, polCalDone = 0;
  logic fskCalStart, polCalStart, gainHigh;
  logic [7:0] cfgWord, ctlWord;

  int compared = 0, mismatched = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  rxfe_csr u_rxfe_csr (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected item for every read cycle
  initial forever begin
    @(negedge clk); #2;
    if (busRe) begin
      if (expQ.size() == 0) check("unexpected read", busRdata, 8'hxx);
      else check(tagQ.pop_front(), busRdata, expQ.pop_front());
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk); busWe = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); busAddr = a; busRe = 1; expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); busRe = 0;
  endtask

  task automatic doneP(input bit pol);
    @(negedge clk); if (pol) polCalDone = 1; else fskCalDone = 1;
    @(negedge clk); polCalDone = 0; fskCalDone = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(3); rst_n = 1;
    // R1 reset state
    #2; check("R1 starts", {6'd0, polCalStart, fskCalStart}, 8'h00);
    check("R1 gain", {7'd0, gainHigh}, 8'h01);
    rd(A_CFG, 8'h40, "R1 cfg");
    rd(A_CTL, 8'h00, "R1 ctl");
    rd(A_STS, 8'h40, "R1 status");
    // R2 config
    wr(A_CFG, 8'hFF); rd(A_CFG, 8'h7F, "R2 cfg bit7");
    wr(A_CFG, 8'h15); rd(A_CFG, 8'h15, "R2 cfg pattern");
    rd(A_STS, 8'h40, "R7 gain held agc off");
    // R6 status layout and write ignore
    pllLocked = 1; clkAlive = 1;
    rd(A_STS, 8'hE0, "R6 status");
    wr(A_STS, 8'hFF);
    rd(A_STS, 8'hE0, "R6 status write ignored");
    rd(A_CFG, 8'h15, "R6 cfg untouched");
    rd(A_CTL, 8'h00, "R6 ctl untouched");
    // R7 gain loads under AGC
    agcEn = 1; idle(2);
    rd(A_STS, 8'hA0, "R7 gain loaded");
    #2; check("R7 gainHigh", {7'd0, gainHigh}, 8'h00);
    agcEn = 0; wr(A_CFG, 8'h55); idle(2);
    rd(A_STS, 8'hA0, "R7 gain held");
    wr(A_CTL, 8'h40); rd(A_CTL, 8'h40, "R3 lock bit");
    agcEn = 1; idle(3);
    rd(A_STS, 8'hA0, "R7 lock holds gain");
    wr(A_CTL, 8'h00); idle(2);
    rd(A_STS, 8'hE0, "R7 unlock loads gain");
    agcEn = 0;
    // R3 stored bits
    wr(A_CTL, 8'hBC); rd(A_CTL, 8'h0C, "R3 ctl mask");
    wr(A_CTL, 8'h00); rd(A_CTL, 8'h00, "R3 ctl clear");
    // R4 start
    wr(A_CTL, 8'h01);
    #2; check("R4 fsk start pulse", {7'd0, fskCalStart}, 8'h01);
    check("R4 no pol start", {7'd0, polCalStart}, 8'h00);
    @(negedge clk); #2; check("R4 pulse one cycle", {7'd0, fskCalStart}, 8'h00);
    rd(A_CTL, 8'h01, "R4 ctl set");
    rd(A_STS, 8'hE0, "R4 done low");
    wr(A_CTL, 8'h00); rd(A_CTL, 8'h01, "R3 write zero keeps cal");
    // R5 completion
    doneP(1); rd(A_STS, 8'hE0, "R5 stray done ignored");
    doneP(0);
    rd(A_CTL, 8'h00, "R5 self clear");
    rd(A_STS, 8'hE1, "R5 done set");
    wr(A_CTL, 8'h02);
    #2; check("R4 pol start pulse", {7'd0, polCalStart}, 8'h01);
    doneP(1); rd(A_STS, 8'hE3, "R5 pol done");
    wr(A_CTL, 8'h01);
    rd(A_STS, 8'hE2, "R4 done cleared");
    // R9 collision
    @(negedge clk); busAddr = A_CTL; busWdata = 8'h01; busWe = 1; fskCalDone = 1;
    @(negedge clk); busWe = 0; fskCalDone = 0;
    #2; check("R9 restart pulse", {7'd0, fskCalStart}, 8'h01);
    rd(A_CTL, 8'h01, "R9 bit stays");
    rd(A_STS, 8'hE2, "R9 done stays low");
    doneP(0); rd(A_STS, 8'hE3, "R5 after collision");
    // R8 idle and unmapped
    @(negedge clk); busAddr = A_CFG; #2;
    check("R8 re low", busRdata, 8'h00);
    rd(4'd5, 8'h00, "R8 unmapped");
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule